// File: doc/BRIEF.md
# Execution Time Profiler

The block snoops a processor's instruction-fetch address bus and measures how long chosen code regions take to run. Software loads a number of slots, each with an entry address and an exit address. A fetch that hits a slot's entry address records the value of a free-running cycle timer. A later fetch that hits the same slot's exit address closes the interval. The elapsed cycle count then goes into that slot's running statistics: the smallest interval, the largest, a saturating sum and a saturating count of completed intervals. Software derives the mean from the sum and the count.

All slots work at the same time and do not affect one another. Each slot holds at most one open entry. An entry that repeats before its exit restarts the measurement and increments a per-slot restart counter. Configuration and results go through a flat word-addressed register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `exec_time_profiler`

## Requirements
- R1: After reset, for every slot: both addresses are 0, min is all ones, max is 0, sum is 0, count is 0, restart count is 0 and the open flag is 0. The global enable is 0.
- R2: The register address is split into a region index (bits above bit 2) and a field (bits 2:0). Region 0, field 0, bit 0 is the global enable (read/write). All other words in region 0 read as 0. Region s+1 belongs to slot s, with these fields:
  - 0: entry address (read/write)
  - 1: exit address (read/write)
  - 2: min (read-only)
  - 3: max (read-only)
  - 4: sum (read-only)
  - 5: count (read-only)
  - 6: restart count (read-only)
  - 7: reads the open flag in bit 0; writing 1 to bit 0 clears the slot

  Writes to the read-only fields have no effect.
- R3: With enable set, a valid fetch at the entry address opens an interval. A valid fetch at the exit address, N clock edges later, closes it with elapsed value N and increments count by one.
- R4: A closed interval lowers min if it is smaller and raises max if it is larger. It adds its elapsed value to sum. min and max change only when an interval closes.
- R5: An exit-address fetch while the slot has no open interval leaves every statistic and the open flag unchanged.
- R6: An entry-address fetch while an interval is open restarts timing from that fetch and increments the restart count by one.
- R7: When the entry and exit addresses are equal, a hit closes the interval if one is open and otherwise opens one.
- R8: Sum, count and restart count saturate at all ones instead of wrapping.
- R9: A clear restores the R1 statistics and drops the open flag in a single cycle. A clear wins over a fetch hit on that slot in the same cycle.
- R10: A fetch with the valid strobe low, or with the global enable 0, never opens or closes an interval.
- R11: Slots track intervals independently, and may overlap in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch address qualifier |
| fetch_addr_i | input | AW | Instruction fetch address |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | clog2(NUM_SLOTS+1)+3 | Register word address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |

## Verification
The assertions take for granted two properties of the inputs:
- Every interval is shorter than the timer period, so the modular difference equals the true elapsed time.
- The sum is at least as wide as the timer.

The stimulus keeps to both. It runs with a 10-bit timer, keeps every interval under 200 cycles, uses an 11-bit sum, and reaches saturation by repeating intervals rather than by stretching one. Register writes are never issued to an unmapped region while a check depends on one.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic [2:0] {
    FLD_ENTRY = 3'd0,
    FLD_EXIT  = 3'd1,
    FLD_MIN   = 3'd2,
    FLD_MAX   = 3'd3,
    FLD_SUM   = 3'd4,
    FLD_COUNT = 3'd5,
    FLD_RSTRT = 3'd6,
    FLD_CTL   = 3'd7
  } fxp_field_e;

  localparam int FieldBits = 3;
endpackage

// File: rtl/fxp_sat_add.sv
module fxp_sat_add #(
  parameter int W  = 16,
  parameter int IW = 1
) (
  input  logic [W-1:0]  a_i,
  input  logic [IW-1:0] b_i,
  output logic [W-1:0]  sum_o
);
  logic [W:0] ext;

  assign ext   = {1'b0, a_i} + {{(W + 1 - IW){1'b0}}, b_i};
  assign sum_o = ext[W] ? '1 : ext[W-1:0];
endmodule

// File: rtl/fxp_slot.sv
module fxp_slot #(
  parameter int AW = 32,
  parameter int TW = 32,
  parameter int SW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [TW-1:0] now_i,
  input  logic          entry_we_i,
  input  logic          exit_we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          clr_i,
  output logic [AW-1:0] entry_addr_o,
  output logic [AW-1:0] exit_addr_o,
  output logic [TW-1:0] min_o,
  output logic [TW-1:0] max_o,
  output logic [SW-1:0] sum_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] rstrt_o,
  output logic          open_o
);
  logic [AW-1:0] entry_q, exit_q;
  logic [TW-1:0] t0_q, min_q, max_q, elapsed;
  logic [SW-1:0] sum_q, sum_nxt;
  logic [CW-1:0] count_q, count_nxt, rstrt_q, rstrt_nxt;
  logic          open_q;
  logic          live, hit_entry, hit_exit, close_iv, open_iv;

  assign live      = en_i & fetch_valid_i;
  assign hit_entry = live && (fetch_addr_i == entry_q);
  assign hit_exit  = live && (fetch_addr_i == exit_q);
  // exit takes precedence so that equal entry/exit addresses alternate
  assign close_iv  = hit_exit && open_q;
  assign open_iv   = hit_entry && !close_iv;
  assign elapsed   = now_i - t0_q;

  fxp_sat_add #(.W(SW), .IW(TW)) u_sum (
    .a_i(sum_q), .b_i(elapsed), .sum_o(sum_nxt)
  );
  fxp_sat_add #(.W(CW), .IW(1)) u_count (
    .a_i(count_q), .b_i(1'b1), .sum_o(count_nxt)
  );
  fxp_sat_add #(.W(CW), .IW(1)) u_rstrt (
    .a_i(rstrt_q), .b_i(1'b1), .sum_o(rstrt_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
      exit_q  <= '0;
    end else begin
      if (entry_we_i) entry_q <= wdata_i;
      if (exit_we_i)  exit_q  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t0_q    <= '0;
      min_q   <= '1;
      max_q   <= '0;
      sum_q   <= '0;
      count_q <= '0;
      rstrt_q <= '0;
      open_q  <= 1'b0;
    end else if (clr_i) begin
      min_q   <= '1;
      max_q   <= '0;
      sum_q   <= '0;
      count_q <= '0;
      rstrt_q <= '0;
      open_q  <= 1'b0;
    end else if (close_iv) begin
      if (elapsed < min_q) min_q <= elapsed;
      if (elapsed > max_q) max_q <= elapsed;
      sum_q   <= sum_nxt;
      count_q <= count_nxt;
      open_q  <= 1'b0;
    end else if (open_iv) begin
      t0_q   <= now_i;
      open_q <= 1'b1;
      if (open_q) rstrt_q <= rstrt_nxt;
    end
  end

  assign entry_addr_o = entry_q;
  assign exit_addr_o  = exit_q;
  assign min_o        = min_q;
  assign max_o        = max_q;
  assign sum_o        = sum_q;
  assign count_o      = count_q;
  assign rstrt_o      = rstrt_q;
  assign open_o       = open_q;

  a_r4_min_le_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q != '0) |-> (min_q <= max_q));

  a_r8_count_holds_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '1 && !clr_i) |=> (count_q == '1));

  a_r8_sum_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (sum_q >= $past(sum_q)));

  a_r6_rstrt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (rstrt_q >= $past(rstrt_q)));

  a_r5_exit_needs_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !clr_i) |=> $stable(count_q));

  a_r9_clear_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0 && sum_q == '0 && rstrt_q == '0 && !open_q
               && max_q == '0 && min_q == '1));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(en_i && fetch_valid_i) && !clr_i)
      |=> ($stable(open_q) && $stable(count_q) && $stable(rstrt_q)));
endmodule

// File: rtl/exec_time_profiler.sv
module exec_time_profiler
  import fxp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 32,
  parameter int TW        = 32,
  parameter int SW        = 32,
  parameter int CW        = 16,
  parameter int DW        = 32,
  localparam int RAW      = $clog2(NUM_SLOTS + 1) + FieldBits
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o
);
  localparam int RGW = RAW - FieldBits;

  logic [RGW-1:0] region;
  fxp_field_e     field;
  logic           en_q;
  logic [TW-1:0]  now_q;

  logic [AW-1:0] entry_a [NUM_SLOTS];
  logic [AW-1:0] exit_a  [NUM_SLOTS];
  logic [TW-1:0] min_a   [NUM_SLOTS];
  logic [TW-1:0] max_a   [NUM_SLOTS];
  logic [SW-1:0] sum_a   [NUM_SLOTS];
  logic [CW-1:0] count_a [NUM_SLOTS];
  logic [CW-1:0] rstrt_a [NUM_SLOTS];
  logic          open_a  [NUM_SLOTS];

  assign region = reg_addr_i[RAW-1:FieldBits];
  assign field  = fxp_field_e'(reg_addr_i[FieldBits-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      now_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (reg_we_i && region == '0 && field == FLD_ENTRY) en_q <= reg_wdata_i[0];
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic sel_w;
    assign sel_w = reg_we_i && (region == RGW'(g + 1));

    fxp_slot #(.AW(AW), .TW(TW), .SW(SW), .CW(CW)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en_q),
      .fetch_valid_i(fetch_valid_i),
      .fetch_addr_i (fetch_addr_i),
      .now_i        (now_q),
      .entry_we_i   (sel_w && field == FLD_ENTRY),
      .exit_we_i    (sel_w && field == FLD_EXIT),
      .wdata_i      (reg_wdata_i[AW-1:0]),
      .clr_i        (sel_w && field == FLD_CTL && reg_wdata_i[0]),
      .entry_addr_o (entry_a[g]),
      .exit_addr_o  (exit_a[g]),
      .min_o        (min_a[g]),
      .max_o        (max_a[g]),
      .sum_o        (sum_a[g]),
      .count_o      (count_a[g]),
      .rstrt_o      (rstrt_a[g]),
      .open_o       (open_a[g])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (region == '0 && field == FLD_ENTRY) reg_rdata_o[0] = en_q;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (region == RGW'(s + 1)) begin
        case (field)
          FLD_ENTRY: reg_rdata_o = DW'(entry_a[s]);
          FLD_EXIT:  reg_rdata_o = DW'(exit_a[s]);
          FLD_MIN:   reg_rdata_o = DW'(min_a[s]);
          FLD_MAX:   reg_rdata_o = DW'(max_a[s]);
          FLD_SUM:   reg_rdata_o = DW'(sum_a[s]);
          FLD_COUNT: reg_rdata_o = DW'(count_a[s]);
          FLD_RSTRT: reg_rdata_o = DW'(rstrt_a[s]);
          FLD_CTL:   reg_rdata_o = DW'(open_a[s]);
          default:   reg_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/exec_time_profiler_bench.sv
module exec_time_profiler_bench;
  localparam int NS   = 3;
  localparam int AW   = 16;
  localparam int TW   = 10;
  localparam int SW   = 11;
  localparam int CW   = 4;
  localparam int DW   = 32;
  localparam int RAW  = $clog2(NS + 1) + 3;
  localparam int TMAX = (1 << TW) - 1;
  localparam int SMAX = (1 << SW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           valid = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic           we = 1'b0;
  logic [RAW-1:0] raddr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;

  int n_chk = 0;
  int n_fail = 0;
  int rot = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exec_time_profiler #(
    .NUM_SLOTS(NS), .AW(AW), .TW(TW), .SW(SW), .CW(CW), .DW(DW)
  ) u_exec_time_profiler (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(valid), .fetch_addr_i(addr),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // behavioural reference model
  int m_en, m_time, m_el;
  int m_entry[NS], m_exit[NS], m_min[NS], m_max[NS], m_sum[NS];
  int m_cnt[NS], m_rst[NS], m_open[NS], m_t0[NS];

  function automatic void slot_reset(int s);
    m_min[s] = TMAX; m_max[s] = 0; m_sum[s] = 0;
    m_cnt[s] = 0; m_rst[s] = 0; m_open[s] = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_time = 0;
      for (int s = 0; s < NS; s++) begin
        slot_reset(s); m_entry[s] = 0; m_exit[s] = 0; m_t0[s] = 0;
      end
    end else begin
      for (int s = 0; s < NS; s++) begin
        if (we && (int'(raddr) >> 3) == s + 1 && (int'(raddr) & 7) == 7 && wdata[0])
          slot_reset(s);
        else if (m_en != 0 && valid) begin
          if (m_open[s] != 0 && int'(addr) == m_exit[s]) begin
            m_el = (m_time - m_t0[s]) & TMAX;
            if (m_el < m_min[s]) m_min[s] = m_el;
            if (m_el > m_max[s]) m_max[s] = m_el;
            m_sum[s] = (m_sum[s] + m_el > SMAX) ? SMAX : m_sum[s] + m_el;
            m_cnt[s] = (m_cnt[s] == CMAX) ? CMAX : m_cnt[s] + 1;
            m_open[s] = 0;
          end else if (int'(addr) == m_entry[s]) begin
            if (m_open[s] != 0) m_rst[s] = (m_rst[s] == CMAX) ? CMAX : m_rst[s] + 1;
            m_t0[s] = m_time;
            m_open[s] = 1;
          end
        end
      end
      if (we) begin
        if (int'(raddr) == 0) m_en = int'(wdata[0]);
        for (int s = 0; s < NS; s++) begin
          if (int'(raddr) == (s + 1) * 8)     m_entry[s] = int'(wdata[AW-1:0]);
          if (int'(raddr) == (s + 1) * 8 + 1) m_exit[s]  = int'(wdata[AW-1:0]);
        end
      end
      m_time = (m_time + 1) & TMAX;
    end
  end

  function automatic int mread(int a);
    int rg, f, s;
    rg = a >> 3; f = a & 7; s = rg - 1;
    if (rg == 0) return (f == 0) ? m_en : 0;
    if (rg > NS) return 0;
    case (f)
      0: return m_entry[s];
      1: return m_exit[s];
      2: return m_min[s];
      3: return m_max[s];
      4: return m_sum[s];
      5: return m_cnt[s];
      6: return m_rst[s];
      default: return m_open[s];
    endcase
  endfunction

  function automatic string ftag(int a);
    case (a & 7)
      2, 3, 4: return "R4";
      5: return "R3";
      6: return "R6";
      7: return "R9";
      default: return "R2";
    endcase
  endfunction

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(rdata) != mread(int'(raddr))) begin
        n_fail++;
        $display("FAIL %s model compare addr=%0d act=%0d exp=%0d",
                 ftag(int'(raddr)), raddr, rdata, mread(int'(raddr)));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int ra(int s, int f);
    return (s + 1) * 8 + f;
  endfunction

  task automatic drive(bit v, int a, bit w, int ad, int d);
    @(negedge clk); #1;
    valid = v; addr = AW'(a); we = w; raddr = RAW'(ad); wdata = DW'(d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, ((rot / 8) % (NS + 1)) * 8 + rot % 8, 0);
      rot++;
    end
  endtask

  task automatic fetch(int a);
    drive(1, a, 0, ra(rot % NS, rot % 8), 0);
    rot++;
  endtask

  task automatic wr(int ad, int d);
    drive(0, 0, 1, ad, d);
  endtask

  task automatic rd(int ad, output int v);
    drive(0, 0, 0, ad, 0);
    @(negedge clk);
    v = int'(rdata);
  endtask

  task automatic expect_reg(string tag, int s, int f, int exp);
    int v;
    rd(ra(s, f), v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(0, v); chk("R1 enable", v, 0);
    for (int s = 0; s < NS; s++) begin
      expect_reg("R1 entry", s, 0, 0);
      expect_reg("R1 exit", s, 1, 0);
      expect_reg("R1 min", s, 2, TMAX);
      expect_reg("R1 max", s, 3, 0);
      expect_reg("R1 sum", s, 4, 0);
      expect_reg("R1 count", s, 5, 0);
      expect_reg("R1 restarts", s, 6, 0);
      expect_reg("R1 open", s, 7, 0);
    end

    // R2 configuration and readback
    wr(ra(0, 0), 'h100); wr(ra(0, 1), 'h180);
    wr(ra(1, 0), 'h200); wr(ra(1, 1), 'h280);
    wr(ra(2, 0), 'h300); wr(ra(2, 1), 'h300);
    wr(ra(0, 3), 77);
    expect_reg("R2 entry readback", 0, 0, 'h100);
    expect_reg("R2 exit readback", 1, 1, 'h280);
    expect_reg("R2 read-only max", 0, 3, 0);

    // R10 disabled: entry ignored
    fetch('h100); idle(2);
    expect_reg("R10 disabled no open", 0, 7, 0);
    wr(0, 1);
    rd(0, v); chk("R2 enable readback", v, 1);
    drive(0, 'h100, 0, ra(0, 7), 0); idle(1);
    expect_reg("R10 invalid strobe no open", 0, 7, 0);

    // R5 exit without entry
    fetch('h180); idle(1);
    expect_reg("R5 count unchanged", 0, 5, 0);
    expect_reg("R5 max unchanged", 0, 3, 0);

    // R3/R4 intervals 7, 3, 12
    fetch('h100); idle(6); fetch('h180); idle(1);
    expect_reg("R3 elapsed as max", 0, 3, 7);
    expect_reg("R3 count one", 0, 5, 1);
    fetch('h100); idle(2); fetch('h180);
    fetch('h100); idle(11); fetch('h180); idle(1);
    expect_reg("R4 min", 0, 2, 3);
    expect_reg("R4 max", 0, 3, 12);
    expect_reg("R4 sum", 0, 4, 22);
    expect_reg("R3 count three", 0, 5, 3);

    // R6 restart on repeated entry
    fetch('h100); idle(2); fetch('h100); idle(4); fetch('h180); idle(1);
    expect_reg("R6 restarts", 0, 6, 1);
    expect_reg("R6 sum uses restart", 0, 4, 27);
    expect_reg("R6 min kept", 0, 2, 3);

    // R11 overlapping slots
    fetch('h100); fetch('h200); idle(2); fetch('h280); fetch('h180); idle(1);
    expect_reg("R11 slot1 elapsed", 1, 3, 3);
    expect_reg("R11 slot1 count", 1, 5, 1);
    expect_reg("R11 slot0 sum", 0, 4, 32);
    expect_reg("R11 slot0 count", 0, 5, 5);

    // R7 same entry and exit address
    fetch('h300); idle(3); fetch('h300); fetch('h300); idle(1);
    expect_reg("R7 closed once", 2, 5, 1);
    expect_reg("R7 elapsed", 2, 3, 4);
    expect_reg("R7 reopened", 2, 7, 1);
    expect_reg("R7 no restart", 2, 6, 0);

    // R9 clear beats same-cycle entry
    drive(1, 'h100, 1, ra(0, 7), 1); idle(1);
    expect_reg("R9 open cleared", 0, 7, 0);
    expect_reg("R9 count cleared", 0, 5, 0);
    expect_reg("R9 min reset", 0, 2, TMAX);
    expect_reg("R9 sum cleared", 0, 4, 0);
    expect_reg("R11 other slot kept", 1, 5, 1);

    // R8 saturation of count and sum
    for (int i = 0; i < 16; i++) begin
      fetch('h200); idle(149); fetch('h280);
    end
    idle(1);
    expect_reg("R8 count saturates", 1, 5, CMAX);
    expect_reg("R8 sum saturates", 1, 4, SMAX);
    expect_reg("R4 max after long runs", 1, 3, 150);

    // R8 restart count saturation, then R6 timing from last entry
    for (int i = 0; i < 17; i++) fetch('h100);
    idle(1);
    expect_reg("R8 restarts saturate", 0, 6, CMAX);
    fetch('h100); idle(2); fetch('h180); idle(1);
    expect_reg("R6 elapsed from last entry", 0, 3, 3);
    expect_reg("R6 count after restarts", 0, 5, 1);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule